// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-side register file of a byte-wide printer port in compatibility mode. A processor reaches it over a small register bus: a 3-bit offset, separate read and write strobes, and 8-bit write and read data. Behind the bus sit three registers: an output data byte, a status byte and a control byte. Status is not a plain storage cell. Control writes and status reads move it through a fixed handshake with the printer, as the host sees that handshake.

A strobe edge written through the control register pushes the held data byte out on a one-cycle byte-valid output. Busy then stays low until a pair of status reads first drops acknowledge and then restores acknowledge together with busy. When that second read completes the acknowledge pulse, an interrupt request is latched and is shown on the interrupt output while interrupts are enabled. A direction bit in the control byte chooses whether a data read returns the held byte or the external input byte.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0x0C, data reads 0x00, and both the byte-valid output and the interrupt output are 0.
- R2: Offset 0 is the data byte, offset 1 is status and offset 2 is control. A write to offset 0 or 2 is stored and reads back unchanged, except that an offset-0 read in input direction follows R8.
- R3: A control write with bit 2 (initialize) at 0 sets status to 0xD8, which is busy-sense bit 7, acknowledge bit 6, online bit 4 and error-sense bit 3 set and all other bits clear.
- R4: A control write with bit 2 at 1 and both bit 3 (select) and bit 0 (strobe) at 1 clears status bit 7 and leaves the other status bits unchanged. Any other control write with bit 2 at 1 leaves status unchanged.
- R5: When a write as in R4 finds the stored strobe bit at 0, the byte-valid output is high for exactly the one cycle after the write and carries the data byte held before the write. If the stored strobe bit was 1, nothing is sent.
- R6: A status read returns the status from before the read. If it finds bit 7 at 0 and stored strobe at 0, then one of two things happens. If bit 6 is 1, it clears bit 6. If bit 6 is 0, it sets both bit 6 and bit 7, and this completes the acknowledge pulse.
- R7: A status read that finds status bit 7 at 1, or stored strobe at 1, leaves status unchanged.
- R8: A read of offset 0 returns the external input byte when control bit 5 (direction) is 1. When that bit is 0, it returns the last written data byte.
- R9: A status read that completes an acknowledge pulse sets a pending interrupt. Every other status read, and any control write with bit 4 (interrupt enable) at 0, clears it. The interrupt output is the pending interrupt gated by control bit 4.
- R10: Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register and send nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and register state |
| ext_din | input | 8 | Byte presented by the peripheral in input direction |
| tx_valid | output | 1 | One-cycle pulse when a byte is sent |
| tx_byte | output | 8 | Byte sent, valid with tx_valid |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 3-bit offset and a two-stage reset synchronizer. The 3-bit offset exposes all five unused offsets, so the bench can hit the 0xFF fill value and confirm that writes to those offsets are dropped. The two-stage synchronizer puts a fixed wait after reset release, and the bench waits this out before its first access. Because status is checked against a bench model on every read, random sequences of control writes and status reads reach the strobe-on-strobe, read-while-busy and enable-cleared-while-pending orderings as well as the directed handshake.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int unsigned BYTE_W = 8;

  // register offsets
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CTRL = 2;

  // status bit positions
  localparam int unsigned ST_NBUSY  = 7;
  localparam int unsigned ST_ACK    = 6;
  localparam int unsigned ST_PAPER  = 5;
  localparam int unsigned ST_ONLINE = 4;
  localparam int unsigned ST_NERR   = 3;
  localparam int unsigned ST_TMO    = 0;

  // control bit positions
  localparam int unsigned CT_DIR  = 5;
  localparam int unsigned CT_IEN  = 4;
  localparam int unsigned CT_SEL  = 3;
  localparam int unsigned CT_INIT = 2;
  localparam int unsigned CT_AFD  = 1;
  localparam int unsigned CT_STB  = 0;

  localparam logic [BYTE_W-1:0] STS_RST  = 8'hD9;
  localparam logic [BYTE_W-1:0] STS_INIT = 8'hD8;
  localparam logic [BYTE_W-1:0] CTL_RST  = 8'h0C;
  localparam logic [BYTE_W-1:0] RD_FILL  = 8'hFF;
endpackage

// File: rtl/prn_rst_sync.sv
module prn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign rst_no = sync_q[N-1];
endmodule

// File: rtl/prn_hostregs.sv
module prn_hostregs
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  logic              send;
  logic              tx_v_d;
  logic [BYTE_W-1:0] data_d, ctl_d, tx_b_d;

  // next state
  always_comb begin
    send   = ctl_we && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]
             && !ctl_q[CT_STB];
    data_d = wdata;
    ctl_d  = wdata;
    tx_v_d = send;
    tx_b_d = data_q;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= CTL_RST;
    end else begin
      if (data_we) data_q <= data_d;
      if (ctl_we)  ctl_q  <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= tx_v_d;
      if (send) tx_byte <= tx_b_d;
    end
  end

  // R5
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  // R5
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(ctl_we));
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              wr_init,
  input  logic              wr_sel,
  input  logic              wr_stb,
  input  logic              wr_ien,
  input  logic              sts_re,
  input  logic              cur_stb,
  input  logic              cur_ien,
  output logic [BYTE_W-1:0] sts_q,
  output logic              irq
);
  logic [BYTE_W-1:0] sts_d;
  logic              pend_q, pend_d;
  logic              sts_en, pend_en;
  logic              rd_armed, rd_done;

  // next state
  always_comb begin
    rd_armed = !sts_q[ST_NBUSY] && !cur_stb;
    rd_done  = rd_armed && !sts_q[ST_ACK];
    sts_d    = sts_q;
    pend_d   = pend_q;
    sts_en   = 1'b0;
    pend_en  = 1'b0;
    if (ctl_we) begin
      if (!wr_init) begin
        sts_d  = STS_INIT;
        sts_en = 1'b1;
      end else if (wr_sel && wr_stb) begin
        sts_d[ST_NBUSY] = 1'b0;
        sts_en          = 1'b1;
      end
      if (!wr_ien) begin
        pend_d  = 1'b0;
        pend_en = 1'b1;
      end
    end else if (sts_re) begin
      pend_d  = rd_done;
      pend_en = 1'b1;
      if (rd_armed) begin
        sts_en = 1'b1;
        if (sts_q[ST_ACK]) begin
          sts_d[ST_ACK] = 1'b0;
        end else begin
          sts_d[ST_ACK]   = 1'b1;
          sts_d[ST_NBUSY] = 1'b1;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= STS_RST;
      pend_q <= 1'b0;
    end else begin
      if (sts_en)  sts_q  <= sts_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign irq = pend_q && cur_ien;

  // R3
  init_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wr_init) |=> (sts_q == STS_INIT));

  // R4
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && wr_init && wr_sel && wr_stb) |=> !sts_q[ST_NBUSY]);

  // R6
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && !ctl_we && !sts_q[ST_NBUSY] && !cur_stb && sts_q[ST_ACK])
      |=> (!sts_q[ST_ACK] && !sts_q[ST_NBUSY]));

  // R7
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && !ctl_we && (sts_q[ST_NBUSY] || cur_stb)) |=> $stable(sts_q));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && !ctl_we && !(!sts_q[ST_NBUSY] && !cur_stb && !sts_q[ST_ACK]))
      |=> !irq);
endmodule

// File: rtl/prn_rdmux.sv
module prn_rdmux
  import prn_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data_q,
  input  logic [BYTE_W-1:0] sts_q,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic [BYTE_W-1:0] ext_din,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    case (addr)
      ADDR_W'(OFS_DATA): rdata = ctl_q[CT_DIR] ? ext_din : data_q;
      ADDR_W'(OFS_STAT): rdata = sts_q;
      ADDR_W'(OFS_CTRL): rdata = ctl_q;
      default:           rdata = RD_FILL;
    endcase
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] ext_din,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic              rst_s_n;
  logic              data_we, ctl_we, sts_re;
  logic [BYTE_W-1:0] data_q, ctl_q, sts_q;

  prn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  // access decode; a write takes precedence over a read
  always_comb begin
    data_we = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
    ctl_we  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    sts_re  = bus_rd && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  end

  prn_hostregs u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .data_we  (data_we),
    .ctl_we   (ctl_we),
    .wdata    (bus_wdata),
    .data_q   (data_q),
    .ctl_q    (ctl_q),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte)
  );

  prn_handshake u_hs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ctl_we  (ctl_we),
    .wr_init (bus_wdata[CT_INIT]),
    .wr_sel  (bus_wdata[CT_SEL]),
    .wr_stb  (bus_wdata[CT_STB]),
    .wr_ien  (bus_wdata[CT_IEN]),
    .sts_re  (sts_re),
    .cur_stb (ctl_q[CT_STB]),
    .cur_ien (ctl_q[CT_IEN]),
    .sts_q   (sts_q),
    .irq     (irq)
  );

  prn_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr    (bus_addr),
    .data_q  (data_q),
    .sts_q   (sts_q),
    .ctl_q   (ctl_q),
    .ext_din (ext_din),
    .rdata   (bus_rdata)
  );

  // R10
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && (bus_addr != ADDR_W'(OFS_DATA)) && (bus_addr != ADDR_W'(OFS_CTRL)))
      |=> ($stable(data_q) && $stable(ctl_q) && !tx_valid));
endmodule

// File: tb/prn_port_regs_test.sv
`timescale 1ns/1ps
module prn_port_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] ext_din = '0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq;

  always #4 clk = ~clk;

  prn_port_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_din(ext_din), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;

  // bench model
  logic [7:0] m_sts, m_ctl, m_data, m_txb;
  logic       m_pend, m_txv;

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0:    return m_ctl[5] ? ext_din : m_data;
      3'd1:    return m_sts;
      3'd2:    return m_ctl;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic observe();
    chk("R5 tx_valid", {7'b0, tx_valid}, {7'b0, m_txv});
    if (m_txv) chk("R5 tx_byte", tx_byte, m_txb);
    chk("R9 irq", {7'b0, irq}, {7'b0, m_pend & m_ctl[4]});
  endtask

  task automatic model_update(bit w, logic [2:0] a, logic [7:0] d);
    logic [7:0] old;
    m_txv = 1'b0;
    if (w) begin
      if (a == 3'd0) m_data = d;
      else if (a == 3'd2) begin
        old   = m_ctl;
        m_ctl = d;
        if (!d[2]) m_sts = 8'hD8;
        else if (d[3] && d[0]) begin
          m_sts[7] = 1'b0;
          if (!old[0]) begin
            m_txv = 1'b1;
            m_txb = m_data;
          end
        end
        if (!d[4]) m_pend = 1'b0;
      end
    end else if (a == 3'd1) begin
      m_pend = 1'b0;
      if (!m_sts[7] && !m_ctl[0]) begin
        if (m_sts[6]) m_sts[6] = 1'b0;
        else begin
          m_sts[6] = 1'b1;
          m_sts[7] = 1'b1;
          m_pend   = 1'b1;
        end
      end
    end
  endtask

  task automatic do_op(bit w, logic [2:0] a, logic [7:0] d, string req);
    @(negedge clk);
    observe();
    bus_addr  = a;
    bus_wr    = w;
    bus_rd    = !w;
    bus_wdata = d;
    #1;
    if (!w) chk(req, bus_rdata, exp_rd(a));
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    model_update(w, a, d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0] ra;
    logic [7:0] rd;
    void'($urandom(32'h5EED_0417));
    m_sts = 8'hD9; m_ctl = 8'h0C; m_data = 8'h00;
    m_pend = 1'b0; m_txv = 1'b0; m_txb = 8'h00;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    do_op(0, 3'd1, 8'h00, "R1 status reset");
    do_op(0, 3'd2, 8'h00, "R1 control reset");
    do_op(0, 3'd0, 8'h00, "R1 data reset");

    // R2 data storage
    do_op(1, 3'd0, 8'hA5, "R2");
    do_op(0, 3'd0, 8'h00, "R2 data readback");

    // R4 R5 strobe sends the byte, busy drops
    do_op(1, 3'd2, 8'h1D, "R5");
    do_op(0, 3'd1, 8'h00, "R4 busy cleared");
    // R7 strobe still high: status read changes nothing
    do_op(0, 3'd1, 8'h00, "R7 quiet read");
    do_op(1, 3'd2, 8'h1C, "R4");
    do_op(0, 3'd2, 8'h00, "R2 control readback");
    // R6 handshake: ack low, then ack and busy restored
    do_op(0, 3'd1, 8'h00, "R6 first read");
    do_op(0, 3'd1, 8'h00, "R6 second read");
    do_op(0, 3'd1, 8'h00, "R6 restored");   // R9 irq seen before, cleared after
    do_op(0, 3'd2, 8'h00, "R9 after clear");

    // R3 initialize
    do_op(1, 3'd2, 8'h18, "R3");
    do_op(0, 3'd1, 8'h00, "R3 init status");
    // R5 no resend while strobe stays high
    do_op(1, 3'd2, 8'h0D, "R5 send");
    do_op(1, 3'd2, 8'h0D, "R5 no resend");
    do_op(0, 3'd1, 8'h00, "R4 status");

    // R8 direction select
    ext_din = 8'h3C;
    do_op(1, 3'd2, 8'h2C, "R8");
    do_op(0, 3'd0, 8'h00, "R8 input direction");
    do_op(1, 3'd2, 8'h0C, "R8");
    do_op(0, 3'd0, 8'h00, "R8 output direction");

    // R9 enable cleared while pending
    do_op(1, 3'd2, 8'h1D, "R9");
    do_op(1, 3'd2, 8'h1C, "R9");
    do_op(0, 3'd1, 8'h00, "R9 read a");
    do_op(0, 3'd1, 8'h00, "R9 read b");
    do_op(1, 3'd2, 8'h0C, "R9 disable");
    do_op(1, 3'd2, 8'h1C, "R9 re-enable stays low");

    // R10 holes and status writes ignored
    for (int i = 3; i < 8; i++) do_op(1, 3'(i), 8'h00, "R10");
    do_op(1, 3'd1, 8'h00, "R10");
    for (int i = 0; i < 8; i++) do_op(0, 3'(i), 8'h00, "R10 readback");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      ra = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) ra = 3'($urandom_range(0, 2));
      rd = 8'($urandom);
      if (ra == 3'd2 && $urandom_range(0, 3) != 0) rd[2] = 1'b1;
      ext_din = 8'($urandom);
      do_op($urandom_range(0, 1) == 1, ra, rd, "R2 R6 R10 random");
    end
    @(negedge clk);
    observe();
    finish_run();
  end
endmodule